// File: doc/BRIEF.md
# Frame Skew Meter with Per-Stream Input Delay

This block finds how far one chosen frame pulse trails the master frame pulse, in steps of half a clock period. Software writes a start command. The block then waits for the next master pulse and counts half-clock sample points until the pulse under test is first seen high. The count is latched into a status register together with a completion flag. Software uses that number to choose a sampling delay for each serial input stream.

Each input stream passes through its own delay lane. The lane's 4-bit setting holds the stream back by a whole number of clocks, and can also take the sample on the falling edge. The output is therefore later than the input by a chosen number of half-clock steps, and every stream lines up with the master channel timing. An outside multiplexer picks which pulse is measured; that multiplexer is not part of this block.

Top module: `frame_skew_unit`

## Requirements
- R1: After reset, the status register reads 0, every offset register reads 0 and every serial output is 0.
- R2: A write to address 0 with data bit 0 set starts a measurement. In the cycle after that write edge, the status register reads 0, so the flag and the result are both cleared. Counting begins at the first rising edge after that where the master pulse is sampled high; that edge is step 0.
- R3: Let the evaluated pulse first be seen high at the falling edge that comes just before rising edge c, where c counts rising edges after step 0. The result is then 2c-1.
- R4: If the evaluated pulse is first seen high at rising edge c (c ≥ 1) and was low at the falling edge before it, the result is 2c.
- R5: Evaluated-pulse activity while the block waits for the master pulse, including at the step-0 edge, does not change the result.
- R6: If the evaluated pulse is not seen by rising edge FRAME_CLKS, the result saturates to 2047 and the flag is still set.
- R7: Status is at read address 1: bit 15 is the completion flag, bits 10..0 are the result and all other bits are 0. Both stay unchanged until the next start.
- R8: Offset register 2+s/4 holds the 4-bit field of stream s at bits 4*(s%4)+3..4*(s%4). Bits [2:0] of the field are the code k and bit [3] is the half-step select h. Each register reads back what was written.
- R9: After rising edge t, output s equals input s as sampled at rising edge t-k when h=0. When h=1 it equals input s as sampled at the falling edge just before rising edge t-k. The output is therefore 2k+h half-clocks later than the sample.
- R10: Writes to the status address change neither the status value nor the measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; rising and falling edges both sample |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_waddr | input | ADDR_W | Write address |
| reg_wdata | input | 16 | Write data |
| reg_raddr | input | ADDR_W | Read address |
| reg_rdata | output | 16 | Read data (combinational on the read address) |
| mfp | input | 1 | Master frame pulse, active high |
| eval_fp | input | 1 | Frame pulse under evaluation, active high |
| ser_in | input | NSTREAM | Serial input streams |
| ser_out | output | NSTREAM | Delayed, realigned serial streams |

## Verification
The hardest case to reach is telling odd results from even ones. An odd result is caught only by the falling-edge sampler, in the half period between a rising and a falling edge. The bench raises the evaluated pulse either a quarter period after a rising edge or three quarters after it. It sweeps the target count across small odd and even values and also drives one case that runs to the saturation limit. Each lane's half-step select is checked against input data that changes between the falling edge and the next rising edge, so the two sampling edges see different bits.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
  localparam int DATA_W    = 16;
  localparam int DLY_W     = 11;
  localparam int FIELD_W   = 4;
  localparam int FIELDS_PR = DATA_W / FIELD_W;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_OFS0 = 2;

  typedef enum logic [1:0] {MS_IDLE, MS_ARM, MS_COUNT} meas_st_t;

  // half-clock steps for a hit found at rising edge 'clocks'
  function automatic logic [DLY_W-1:0] half_steps(input logic [DLY_W-1:0] clocks,
                                                  input logic on_fall);
    return (clocks << 1) - {{(DLY_W-1){1'b0}}, on_fall};
  endfunction

  function automatic logic [DLY_W-1:0] sat_value();
    return {DLY_W{1'b1}};
  endfunction
endpackage

// File: rtl/fsu_skew_meter.sv
module fsu_skew_meter
  import fsu_pkg::*;
#(
  parameter int FRAME_CLKS = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mfp,
  input  logic             eval_fp,
  output logic             busy,
  output logic             done,
  output logic [DLY_W-1:0] delay
);
  localparam int CNT_W = $clog2(FRAME_CLKS + 1);

  meas_st_t         st;
  logic [CNT_W-1:0] cyc;
  logic             ev_fall;
  logic             hit_fall, hit_rise, expired;

  // falling-edge sampler of the evaluated pulse
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ev_fall <= 1'b0;
    else        ev_fall <= eval_fp;
  end

  assign hit_fall = (st == MS_COUNT) && ev_fall;
  assign hit_rise = (st == MS_COUNT) && !ev_fall && eval_fp;
  assign expired  = (st == MS_COUNT) && !ev_fall && !eval_fp &&
                    (cyc == CNT_W'(FRAME_CLKS));
  assign busy     = (st != MS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= MS_IDLE;
      cyc   <= '0;
      done  <= 1'b0;
      delay <= '0;
    end else if (start) begin
      st    <= MS_ARM;
      cyc   <= '0;
      done  <= 1'b0;
      delay <= '0;
    end else begin
      case (st)
        MS_ARM: begin
          if (mfp) begin
            st  <= MS_COUNT;
            cyc <= CNT_W'(1);
          end
        end
        MS_COUNT: begin
          if (hit_fall || hit_rise) begin
            delay <= half_steps(DLY_W'(cyc), hit_fall);
            done  <= 1'b1;
            st    <= MS_IDLE;
          end else if (expired) begin
            delay <= sat_value();
            done  <= 1'b1;
            st    <= MS_IDLE;
          end else begin
            cyc <= cyc + CNT_W'(1);
          end
        end
        default: st <= MS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fsu_lane.sv
module fsu_lane #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic [CODE_W-1:0] code,
  input  logic              half_sel,
  output logic              dout
);
  localparam int DEPTH = 2 ** CODE_W;

  logic             fall_q;
  logic [DEPTH-1:0] pipe;
  logic             src;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= din;
  end

  assign src = half_sel ? fall_q : din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[DEPTH-2:0], src};
  end

  assign dout = pipe[code];
endmodule

// File: rtl/fsu_regs.sv
module fsu_regs
  import fsu_pkg::*;
#(
  parameter int NSTREAM = 8,
  parameter int ADDR_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [ADDR_W-1:0]          waddr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [ADDR_W-1:0]          raddr,
  output logic [DATA_W-1:0]          rdata,
  input  logic                       meas_done,
  input  logic [DLY_W-1:0]           meas_delay,
  output logic                       start,
  output logic [NSTREAM*FIELD_W-1:0] cfg
);
  localparam int NREG = (NSTREAM + FIELDS_PR - 1) / FIELDS_PR;

  logic [DATA_W-1:0] ofs [NREG];

  assign start = wr && (waddr == ADDR_W'(ADDR_CTRL)) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) ofs[r] <= '0;
    end else if (wr) begin
      for (int r = 0; r < NREG; r++)
        if (waddr == ADDR_W'(ADDR_OFS0 + r)) ofs[r] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (raddr == ADDR_W'(ADDR_STAT))
      rdata = {meas_done, {(DATA_W-1-DLY_W){1'b0}}, meas_delay};
    for (int r = 0; r < NREG; r++)
      if (raddr == ADDR_W'(ADDR_OFS0 + r)) rdata = ofs[r];
  end

  for (genvar s = 0; s < NSTREAM; s++) begin : g_cfg
    assign cfg[s*FIELD_W +: FIELD_W] =
      ofs[s / FIELDS_PR][(s % FIELDS_PR)*FIELD_W +: FIELD_W];
  end
endmodule

// File: rtl/frame_skew_unit.sv
module frame_skew_unit
  import fsu_pkg::*;
#(
  parameter int NSTREAM    = 8,
  parameter int FRAME_CLKS = 1000,
  parameter int ADDR_W     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_waddr,
  input  logic [15:0]        reg_wdata,
  input  logic [ADDR_W-1:0]  reg_raddr,
  output logic [15:0]        reg_rdata,
  input  logic               mfp,
  input  logic               eval_fp,
  input  logic [NSTREAM-1:0] ser_in,
  output logic [NSTREAM-1:0] ser_out
);
  localparam int CODE_W = FIELD_W - 1;

  logic                       start_w;
  logic                       meas_busy;
  logic                       meas_done;
  logic [DLY_W-1:0]           meas_delay;
  logic [NSTREAM*FIELD_W-1:0] lane_cfg;

  fsu_regs #(.NSTREAM(NSTREAM), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .waddr(reg_waddr),
    .wdata(reg_wdata), .raddr(reg_raddr), .rdata(reg_rdata),
    .meas_done(meas_done), .meas_delay(meas_delay),
    .start(start_w), .cfg(lane_cfg)
  );

  fsu_skew_meter #(.FRAME_CLKS(FRAME_CLKS)) u_meter (
    .clk(clk), .rst_n(rst_n), .start(start_w), .mfp(mfp),
    .eval_fp(eval_fp), .busy(meas_busy), .done(meas_done),
    .delay(meas_delay)
  );

  for (genvar s = 0; s < NSTREAM; s++) begin : g_lane
    fsu_lane #(.CODE_W(CODE_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .din(ser_in[s]),
      .code(lane_cfg[s*FIELD_W +: CODE_W]),
      .half_sel(lane_cfg[s*FIELD_W + CODE_W]),
      .dout(ser_out[s])
    );
  end
endmodule

// File: rtl/frame_skew_unit_chk.sv
module frame_skew_unit_chk #(
  parameter int FRAME_CLKS = 1000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [10:0] delay,
  input logic        ser_in0,
  input logic        ser_out0,
  input logic [3:0]  cfg0
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && busy));

  a_r2_busy_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  a_r7_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(delay)));

  a_r6_result_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((32'(delay) <= 2*FRAME_CLKS) || (&delay)));

  a_r3_done_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  a_r9_lane0_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && cfg0 == 4'd0 && $past(cfg0) == 4'd0) |-> (ser_out0 == $past(ser_in0)));
endmodule

bind frame_skew_unit frame_skew_unit_chk #(.FRAME_CLKS(FRAME_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start_w), .busy(meas_busy),
  .done(meas_done), .delay(meas_delay), .ser_in0(ser_in[0]),
  .ser_out0(ser_out[0]), .cfg0(lane_cfg[3:0])
);

// File: tb/tb_frame_skew_unit.sv
module tb_frame_skew_unit;
  localparam int NS = 8;
  localparam int FRAME = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_waddr = '0;
  logic [15:0] reg_wdata = '0;
  logic [3:0]  reg_raddr = 4'd1;
  logic [15:0] reg_rdata;
  logic        mfp = 1'b0;
  logic        eval_fp = 1'b0;
  logic [NS-1:0] ser_in = '0;
  logic [NS-1:0] ser_out;

  int n_chk = 0;
  int n_fail = 0;

  frame_skew_unit #(.NSTREAM(NS), .FRAME_CLKS(FRAME), .ADDR_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .mfp(mfp), .eval_fp(eval_fp), .ser_in(ser_in), .ser_out(ser_out)
  );

  always #10 clk = ~clk;

  // bench copy of offset registers and its own sample history
  logic [15:0] ofs_m [2];
  logic [NS-1:0] pos_h [16];
  logic [NS-1:0] neg_h [16];
  int kk = 0;
  int settle_k = 1 << 20;
  int sb [$];
  logic prev_done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // serial stimulus changes three quarters into the cycle
  always @(posedge clk) begin
    #15;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ser_in = lfsr[NS-1:0] ^ lfsr[15:8];
  end

  always @(negedge clk) neg_h[(kk + 1) % 16] = ser_in;

  // monitor: lane scoreboard and measurement completion scoreboard
  always @(posedge clk) begin
    kk = kk + 1;
    pos_h[kk % 16] = ser_in;
    #8;
    if (rst_n && kk - settle_k >= 8) begin
      for (int s = 0; s < NS; s++) begin
        logic [3:0] f;
        int idx;
        logic e;
        f = ofs_m[s / 4][(s % 4)*4 +: 4];
        idx = (kk - int'(f[2:0])) & 15;
        e = f[3] ? neg_h[idx][s] : pos_h[idx][s];
        check(ser_out[s] == e, "R9 lane output", int'(ser_out[s]), int'(e));
      end
    end
    if (rst_n && reg_raddr == 4'd1) begin
      if (reg_rdata[15] && !prev_done) begin
        if (sb.size() == 0) begin
          check(1'b0, "R3 unexpected completion", int'(reg_rdata[10:0]), -1);
        end else begin
          int ex;
          ex = sb.pop_front();
          check(reg_rdata[10:0] == 11'(ex), "R3/R4/R6 measured delay", int'(reg_rdata[10:0]), ex);
          check(reg_rdata[14:11] == 4'd0, "R7 unused status bits", int'(reg_rdata[14:11]), 0);
        end
      end
      prev_done = reg_rdata[15];
    end
  end

  task automatic reg_write(input logic [3:0] a, input logic [15:0] d);
    @(posedge clk); #5;
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(posedge clk); #5;
    reg_wr = 1'b0;
  endtask

  task automatic read_chk(input logic [3:0] a, input logic [15:0] exp, input string req);
    reg_raddr = a;
    #1;
    check(reg_rdata == exp, req, int'(reg_rdata), int'(exp));
    reg_raddr = 4'd1;
  endtask

  task automatic set_offsets(input logic [15:0] r0, input logic [15:0] r1);
    reg_write(4'd2, r0);
    ofs_m[0] = r0;
    settle_k = kk;
    reg_write(4'd3, r1);
    ofs_m[1] = r1;
    settle_k = kk;
    read_chk(4'd2, r0, "R8 offset readback reg2");
    read_chk(4'd3, r1, "R8 offset readback reg3");
    repeat (40) @(posedge clk);
    #5;
  endtask

  // n: expected half-clock count (0 = no evaluated pulse, expect saturation)
  task automatic measure(input int n, input bit noise);
    sb.push_back(n == 0 ? 2047 : n);
    reg_write(4'd0, 16'h0001);
    check(reg_rdata == 16'h0000, "R2 status cleared after start", int'(reg_rdata), 0);
    if (noise) begin
      eval_fp = 1'b1;           // seen at a falling edge while waiting (R5)
      #10;
      eval_fp = 1'b0;
      #0;
    end else begin
      #10;
    end
    mfp = 1'b1;
    @(posedge clk); #5;         // step 0
    mfp = 1'b0;
    if (n != 0) begin
      if (n % 2 == 1) begin
        int i;
        i = (n - 1) / 2;
        if (i > 0) begin repeat (i) @(posedge clk); #5; end
      end else begin
        int j;
        j = n / 2;
        if (j == 1) #10;
        else begin repeat (j - 1) @(posedge clk); #15; end
      end
      eval_fp = 1'b1;
    end
    while (sb.size() != 0) @(posedge clk);
    @(posedge clk); #5;
    eval_fp = 1'b0;
  endtask

  initial begin
    ofs_m[0] = '0;
    ofs_m[1] = '0;
    #45;
    rst_n = 1'b1;
    #1;
    // R1 reset state
    read_chk(4'd1, 16'h0000, "R1 status after reset");
    read_chk(4'd2, 16'h0000, "R1 offset reg2 after reset");
    read_chk(4'd3, 16'h0000, "R1 offset reg3 after reset");
    check(ser_out == '0, "R1 outputs after reset", int'(ser_out), 0);
    @(posedge clk); #5;
    settle_k = kk;

    // R9 lane delays, several settings
    set_offsets(16'h0000, 16'h0000);
    set_offsets(16'hF0A1, 16'h83E5);
    set_offsets(16'h7B2C, 16'h9D46);
    set_offsets(16'h8888, 16'hFFFF);

    // R3 odd / R4 even counts
    measure(1, 1'b0);
    measure(2, 1'b0);
    measure(3, 1'b0);
    measure(4, 1'b0);
    measure(9, 1'b0);
    measure(12, 1'b0);
    // R5 activity while waiting is ignored
    measure(5, 1'b1);
    measure(6, 1'b1);

    // R7 result held; R10 write to status ignored
    repeat (5) @(posedge clk); #5;
    read_chk(4'd1, 16'h8006, "R7 status held after completion");
    reg_write(4'd1, 16'hFFFF);
    repeat (3) @(posedge clk); #5;
    read_chk(4'd1, 16'h8006, "R10 status write ignored");
    read_chk(4'd0, 16'h0000, "R7 control address reads zero");

    // R6 no evaluated pulse within the frame
    measure(0, 1'b0);
    read_chk(4'd1, 16'h87FF, "R6 saturated status");
    measure(7, 1'b0);

    repeat (20) @(posedge clk); #5;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #3000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule